// File: doc/BRIEF.md
# Receive DMA Steering Engine with FIFO Pre-Drain

This block sits between a serial receiver's byte stream, an external receive FIFO and a byte-wide memory write port. Software points it at a buffer by writing a start address, then requests a transfer by writing a length. The engine first moves whatever bytes the FIFO already holds into memory, up to the requested length. Any bytes still owed after that are tracked in a remaining-count register. Later incoming bytes then bypass the FIFO and go straight to memory until the count reaches zero. Once the count is zero, incoming bytes go into the FIFO again.

Writing the address register abandons any pending or in-flight transfer. The remaining count and the current pointer are visible as plain outputs. A level-style interrupt term is raised whenever it is enabled and no bytes are owed. Every data path uses valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. A sender keeps valid high and its payload unchanged until it sees ready. While a drain is running, the incoming stream is held off with `in_ready` low. The memory port can stall either source for any number of cycles.

Top module: `rxdma_steer`

## Requirements
- R1: A pulse on `addr_wr` loads `rx_ptr` with `addr_wdata` and clears `rem_count` to zero on the next edge. It also stops any drain in progress. When `addr_wr` and `cnt_wr` pulse in the same cycle, the address write wins and the length write is dropped.
- R2: A length write of L while not draining, with FIFO occupancy N smaller than L, sets `rem_count` to L-N and drains all N FIFO bytes to memory.
- R3: A length write of L while not draining, with N at least L, sets `rem_count` to 0 and drains exactly L bytes, leaving N-L in the FIFO.
- R4: Drained bytes leave in FIFO order on the memory port at consecutive addresses, starting at `rx_ptr`. Afterwards `rx_ptr` points one past the last byte written.
- R5: While `rem_count` is nonzero and no drain runs, each accepted incoming byte is written to memory at `rx_ptr`. The pointer then increments by one and `rem_count` decrements by one. No such byte is offered to the FIFO.
- R6: While `rem_count` is zero and no drain runs, incoming bytes are passed to the FIFO write stream and none reach memory.
- R7: During a drain, `in_ready` is held low.
- R8: A length write that arrives while a drain is in progress is ignored. `rem_count` and the drain length are unchanged by it.
- R9: `irq_term` is high exactly when `irq_en` is high and `rem_count` is zero.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Start-address write strobe (cancels) |
| addr_wdata | input | ADDR_W | Start address value |
| cnt_wr | input | 1 | Length write strobe (starts) |
| cnt_wdata | input | CNT_W | Requested length in bytes |
| irq_en | input | 1 | Enable for the completion interrupt term |
| rem_count | output | CNT_W | Bytes still owed to memory |
| rx_ptr | output | ADDR_W | Current destination pointer |
| irq_term | output | 1 | Completion interrupt term |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Incoming byte accepted |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| fifo_rd_valid | input | 1 | FIFO head byte valid |
| fifo_rd_data | input | 8 | FIFO head byte |
| fifo_rd_ready | output | 1 | Pop strobe toward the FIFO |
| fifo_wr_valid | output | 1 | Push request toward the FIFO |
| fifo_wr_data | output | 8 | Byte to push |
| fifo_wr_ready | input | 1 | FIFO has room |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
The properties assume that `fifo_level` agrees with the FIFO's own valid flag. That means the head byte is valid whenever the occupancy is nonzero, and the occupancy never exceeds the FIFO depth. The properties also assume that the strobes and the stream sources change only between edges and respect the hold rule. The bench's FIFO model derives its level and valid from the same read and write counters, and it refuses pushes at its depth. Every stimulus is applied on the falling edge, and each byte is held until it is taken. Memory stalls are produced by toggling `mem_ready`, which exercises the address hold during drains.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  // Where bytes are routed this cycle.
  typedef enum logic [1:0] {
    ROUTE_FIFO   = 2'd0,  // incoming bytes fill the FIFO
    ROUTE_DRAIN  = 2'd1,  // FIFO head is copied to memory
    ROUTE_DIRECT = 2'd2   // incoming bytes go straight to memory
  } route_e;
endpackage

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             xfer_fire,
  output route_e           route,
  output logic [CNT_W-1:0] rem_count
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] drain_left_q;
  logic             draining_q;

  logic [CNT_W-1:0] level_ext;
  logic             short_fill;
  logic [CNT_W-1:0] take_n;
  logic [CNT_W-1:0] owe_n;
  logic             start_ok;

  assign level_ext  = CNT_W'(fifo_level);
  assign short_fill = level_ext < cnt_wdata;
  assign take_n     = short_fill ? level_ext : cnt_wdata;
  assign owe_n      = short_fill ? (cnt_wdata - level_ext) : '0;
  // Length writes are dropped while a drain runs.
  assign start_ok   = cnt_wr && !draining_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q        <= '0;
      drain_left_q <= '0;
      draining_q   <= 1'b0;
    end else if (addr_wr) begin
      rem_q        <= '0;
      drain_left_q <= '0;
      draining_q   <= 1'b0;
    end else if (start_ok) begin
      rem_q        <= owe_n;
      drain_left_q <= take_n;
      draining_q   <= (take_n != '0);
    end else if (xfer_fire) begin
      if (draining_q) begin
        drain_left_q <= drain_left_q - 1'b1;
        if (drain_left_q == CNT_W'(1)) draining_q <= 1'b0;
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (draining_q)          route = ROUTE_DRAIN;
    else if (rem_q != '0)    route = ROUTE_DIRECT;
    else                     route = ROUTE_FIFO;
  end

  assign rem_count = rem_q;
endmodule

// File: rtl/rxdma_ptr.sv
module rxdma_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              xfer_fire,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (addr_wr)   ptr_q <= addr_wdata;
    else if (xfer_fire) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rxdma_route.sv
module rxdma_route
  import rxdma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  route_e            route,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              fifo_rd_valid,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              fifo_rd_ready,
  output logic              fifo_wr_valid,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic              fifo_wr_ready,
  output logic              mem_valid,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ready,
  output logic              xfer_fire
);
  always_comb begin
    in_ready      = 1'b0;
    fifo_rd_ready = 1'b0;
    fifo_wr_valid = 1'b0;
    mem_valid     = 1'b0;
    mem_data      = in_data;
    fifo_wr_data  = in_data;
    unique case (route)
      ROUTE_DRAIN: begin
        mem_valid     = fifo_rd_valid;
        mem_data      = fifo_rd_data;
        fifo_rd_ready = fifo_rd_valid && mem_ready;
      end
      ROUTE_DIRECT: begin
        mem_valid = in_valid;
        in_ready  = mem_ready;
      end
      default: begin
        fifo_wr_valid = in_valid;
        in_ready      = fifo_wr_ready;
      end
    endcase
  end

  assign xfer_fire = mem_valid && mem_ready;
endmodule

// File: rtl/rxdma_steer.sv
module rxdma_steer
  import rxdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              irq_en,
  output logic [CNT_W-1:0]  rem_count,
  output logic [ADDR_W-1:0] rx_ptr,
  output logic              irq_term,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_rd_valid,
  input  logic [7:0]        fifo_rd_data,
  output logic              fifo_rd_ready,
  output logic              fifo_wr_valid,
  output logic [7:0]        fifo_wr_data,
  input  logic              fifo_wr_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  input  logic              mem_ready
);
  route_e route;
  logic   xfer_fire;

  rxdma_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_wr    (addr_wr),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .fifo_level (fifo_level),
    .xfer_fire  (xfer_fire),
    .route      (route),
    .rem_count  (rem_count)
  );

  rxdma_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .xfer_fire  (xfer_fire),
    .ptr        (rx_ptr)
  );

  rxdma_route #(.DATA_W(8)) i_route (
    .route         (route),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .fifo_rd_valid (fifo_rd_valid),
    .fifo_rd_data  (fifo_rd_data),
    .fifo_rd_ready (fifo_rd_ready),
    .fifo_wr_valid (fifo_wr_valid),
    .fifo_wr_data  (fifo_wr_data),
    .fifo_wr_ready (fifo_wr_ready),
    .mem_valid     (mem_valid),
    .mem_data      (mem_data),
    .mem_ready     (mem_ready),
    .xfer_fire     (xfer_fire)
  );

  assign mem_addr = rx_ptr;
  assign irq_term = irq_en && (rem_count == '0);
endmodule

// File: rtl/rxdma_steer_chk.sv
module rxdma_steer_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_wr,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic              cnt_wr,
  input logic              irq_en,
  input logic [CNT_W-1:0]  rem_count,
  input logic [ADDR_W-1:0] rx_ptr,
  input logic              irq_term,
  input logic              in_ready,
  input logic              fifo_rd_ready,
  input logic              fifo_wr_valid,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready
);
  p_cancel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (rem_count == '0) && (rx_ptr == $past(addr_wdata)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !addr_wr) |=> rx_ptr == $past(rx_ptr) + 1'b1);

  p_direct_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !fifo_rd_ready && rem_count != '0 && !addr_wr && !cnt_wr)
      |=> rem_count == $past(rem_count) - 1'b1);

  p_no_push_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_count != '0) |-> !fifo_wr_valid);

  p_single_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_valid && mem_valid));

  p_hold_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_ready |-> !in_ready);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_count != '0) |-> !irq_term);

  p_stall_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !addr_wr) |=> mem_addr == $past(mem_addr));
endmodule

bind rxdma_steer rxdma_steer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_wr       (addr_wr),
  .addr_wdata    (addr_wdata),
  .cnt_wr        (cnt_wr),
  .irq_en        (irq_en),
  .rem_count     (rem_count),
  .rx_ptr        (rx_ptr),
  .irq_term      (irq_term),
  .in_ready      (in_ready),
  .fifo_rd_ready (fifo_rd_ready),
  .fifo_wr_valid (fifo_wr_valid),
  .mem_valid     (mem_valid),
  .mem_addr      (mem_addr),
  .mem_ready     (mem_ready)
);

// File: tb/test_rxdma_steer.sv
module test_rxdma_steer;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              addr_wr = 1'b0;
  logic [ADDR_W-1:0] addr_wdata = '0;
  logic              cnt_wr = 1'b0;
  logic [CNT_W-1:0]  cnt_wdata = '0;
  logic              irq_en = 1'b0;
  logic [CNT_W-1:0]  rem_count;
  logic [ADDR_W-1:0] rx_ptr;
  logic              irq_term;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready;
  logic [LVL_W-1:0]  fifo_level;
  logic              fifo_rd_valid;
  logic [7:0]        fifo_rd_data;
  logic              fifo_rd_ready;
  logic              fifo_wr_valid;
  logic [7:0]        fifo_wr_data;
  logic              fifo_wr_ready;
  logic              mem_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_data;
  logic              mem_ready = 1'b1;
  logic              stall = 1'b0;

  rxdma_steer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) i_rxdma_steer (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .irq_en(irq_en),
    .rem_count(rem_count), .rx_ptr(rx_ptr), .irq_term(irq_term),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fifo_level(fifo_level), .fifo_rd_valid(fifo_rd_valid),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_ready(fifo_rd_ready),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
    .fifo_wr_ready(fifo_wr_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready)
  );

  // FIFO model
  logic [7:0] fq [0:63];
  int fwp = 0;
  int frp = 0;
  assign fifo_level    = LVL_W'(fwp - frp);
  assign fifo_rd_valid = (fwp != frp);
  assign fifo_rd_data  = fq[frp % 64];
  assign fifo_wr_ready = (fwp - frp) < DEPTH;

  // memory log
  logic [ADDR_W-1:0] log_a [0:63];
  logic [7:0]        log_d [0:63];
  int log_n = 0;

  always @(posedge clk) begin
    if (fifo_wr_valid && fifo_wr_ready) begin
      fq[fwp % 64] <= fifo_wr_data;
      fwp <= fwp + 1;
    end
    if (fifo_rd_valid && fifo_rd_ready) frp <= frp + 1;
    if (mem_valid && mem_ready) begin
      log_a[log_n % 64] <= mem_addr;
      log_d[log_n % 64] <= mem_data;
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) mem_ready = stall ? ~mem_ready : 1'b1;

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_addr(input logic [ADDR_W-1:0] a);
    @(negedge clk); addr_wr = 1'b1; addr_wdata = a;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CNT_W-1:0] c);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = c;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic chk_log(input int idx, input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
    chk(log_a[idx] == a, req, log_a[idx], a);
    chk(log_d[idx] == d, req, 32'(log_d[idx]), 32'(d));
  endtask

  task automatic t_reset;
    idle(1);
    chk(rem_count == 0, "R9 reset rem", rem_count, 0);
    chk(rx_ptr == 0, "R1 reset ptr", rx_ptr, 0);
    chk(irq_term == 1'b0, "R9 irq off when disabled", irq_term, 0);
    chk(mem_valid == 1'b0, "R6 no mem at reset", mem_valid, 0);
    irq_en = 1'b1;
    idle(1);
    chk(irq_term == 1'b1, "R9 irq on when enabled and rem zero", irq_term, 1);
  endtask

  task automatic t_fifo_fill;   // R6
    send(8'hA1); send(8'hA2); send(8'hA3);
    idle(2);
    chk(fifo_level == 3, "R6 fifo level", fifo_level, 3);
    chk(log_n == 0, "R6 nothing to memory", log_n, 0);
    chk(fq[2] == 8'hA3, "R6 fifo content", fq[2], 8'hA3);
  endtask

  task automatic t_partial_drain;  // R2 R4 R9
    wr_addr(32'h100);
    wr_cnt(16'd5);
    idle(8);
    chk(rem_count == 2, "R2 remaining", rem_count, 2);
    chk(fifo_level == 0, "R2 fifo emptied", fifo_level, 0);
    chk(log_n == 3, "R2 drained count", log_n, 3);
    chk_log(0, 32'h100, 8'hA1, "R4 first");
    chk_log(2, 32'h102, 8'hA3, "R4 last");
    chk(rx_ptr == 32'h103, "R4 ptr after drain", rx_ptr, 32'h103);
    chk(irq_term == 1'b0, "R9 irq low while owed", irq_term, 0);
  endtask

  task automatic t_direct;  // R5 R6 R9
    send(8'hB1); send(8'hB2);
    idle(2);
    chk(log_n == 5, "R5 direct writes", log_n, 5);
    chk_log(3, 32'h103, 8'hB1, "R5 direct first");
    chk_log(4, 32'h104, 8'hB2, "R5 direct second");
    chk(fifo_level == 0, "R5 fifo untouched", fifo_level, 0);
    chk(rem_count == 0, "R5 rem reaches zero", rem_count, 0);
    chk(irq_term == 1'b1, "R9 irq on completion", irq_term, 1);
    send(8'hC1);
    idle(2);
    chk(fifo_level == 1, "R6 back to fifo", fifo_level, 1);
    chk(log_n == 5, "R6 no memory write", log_n, 5);
  endtask

  task automatic t_exact_drain;  // R3 R7 R10
    send(8'hC2); send(8'hC3); send(8'hC4);
    idle(1);
    wr_addr(32'h200);
    stall = 1'b1;
    wr_cnt(16'd2);
    in_valid = 1'b1; in_data = 8'hDD;
    #1;
    chk(in_ready == 1'b0, "R7 input held off during drain", in_ready, 0);
    chk(rem_count == 0, "R3 rem zero", rem_count, 0);
    @(negedge clk); in_valid = 1'b0;
    idle(10);
    stall = 1'b0;
    idle(2);
    chk(log_n == 7, "R3 exactly two drained", log_n, 7);
    chk_log(5, 32'h200, 8'hC1, "R3 first");
    chk_log(6, 32'h201, 8'hC2, "R10 second under stall");
    chk(fifo_level == 2, "R3 leftover", fifo_level, 2);
    chk(rx_ptr == 32'h202, "R4 ptr", rx_ptr, 32'h202);
  endtask

  task automatic t_cnt_during_drain;  // R8
    wr_addr(32'h300);
    stall = 1'b1;
    wr_cnt(16'd1);
    wr_cnt(16'd9);
    idle(8);
    stall = 1'b0;
    idle(2);
    chk(rem_count == 0, "R8 second length ignored", rem_count, 0);
    chk(fifo_level == 1, "R8 only one drained", fifo_level, 1);
    chk_log(7, 32'h300, 8'hC3, "R8 drained byte");
    chk(rx_ptr == 32'h301, "R8 ptr", rx_ptr, 32'h301);
  endtask

  task automatic t_cancel;  // R1
    wr_addr(32'h400);
    wr_cnt(16'd4);
    idle(4);
    chk(rem_count == 3, "R2 rem before cancel", rem_count, 3);
    wr_addr(32'h500);
    #1;
    chk(rem_count == 0, "R1 cancel clears rem", rem_count, 0);
    chk(rx_ptr == 32'h500, "R1 ptr loaded", rx_ptr, 32'h500);
    chk(irq_term == 1'b1, "R9 irq after cancel", irq_term, 1);
    send(8'hE1);
    idle(2);
    chk(fifo_level == 1, "R1 byte goes to fifo after cancel", fifo_level, 1);
    // same-cycle address and length write
    @(negedge clk); addr_wr = 1'b1; addr_wdata = 32'h600; cnt_wr = 1'b1; cnt_wdata = 16'd3;
    @(negedge clk); addr_wr = 1'b0; cnt_wr = 1'b0;
    idle(4);
    chk(rem_count == 0, "R1 address wins over length", rem_count, 0);
    chk(fifo_level == 1, "R1 no drain started", fifo_level, 1);
    chk(rx_ptr == 32'h600, "R1 ptr from same-cycle write", rx_ptr, 32'h600);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fifo_fill();
    t_partial_drain();
    t_direct();
    t_exact_drain();
    t_cnt_during_drain();
    t_cancel();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end
endmodule